// File: doc/BRIEF.md
# Prescaled Countdown Watchdog

This peripheral guards a system against software that has stopped running. Software programs a 16-bit count and a control word over a small register bus (address, write strobe, write data, read data). Once enabled in watchdog mode, the count steps down by one on each tick of a power-of-two prescaler. Software must keep writing the count register to restart the countdown. If the count steps from 1 to 0, the block raises a reset request. That request holds until the block itself is reset.

A load value of zero parks the counter, so no expiry can follow. Mode codes other than the watchdog code let the counter run down to zero without ever requesting a reset. Any write to either register restarts the prescaler. The first tick after a write therefore comes one full division period later. With the undivided prescale code, a load of 1 expires on the very next clock.

Top module: `prescaled_watchdog`

## Requirements
- R1: A read at byte offset 0x00 returns the live count in bits [15:0]. A read at offset 0x08 returns the stored control byte in bits [7:0]. All other bits, and every other offset, read as zero.
- R2: A write to offset 0x00 whose value exceeds 0xFFFF loads 0xFFFF. Smaller values load unchanged.
- R3: The control byte holds the enable in bit 7, the mode in bits [6:4] and the prescale code in bits [3:0]. While bit 7 is clear, the count holds its value.
- R4: Prescale code 0 ticks on every clock. Code c from 1 to 15 ticks once every 2^(c+1) clocks, so code 15 divides by 65536.
- R5: Each tick lowers the count by one. A write to offset 0x00 restarts the countdown from the written value. A write to either register clears the prescaler phase.
- R6: With mode 3 and enable set, a load of L under divisor D raises the reset request exactly L*D clocks after the clock edge that takes the load write.
- R7: Once raised, the reset request stays high until rst_ni is asserted. Later load writes change the stored count, but counting stays stopped.
- R8: A count of zero never decrements and never raises the reset request.
- R9: In any mode other than 3, the count runs down to zero and stops there, and the reset request stays low.
- R10: Rewriting the count register before it reaches zero keeps the reset request low indefinitely.
- R11: After reset, the count, the control byte and the reset request are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte offset of the register access |
| we_i | input | 1 | Write strobe, one clock per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The hardest case to reach is the exact expiry clock at large divisors, since prescale code 15 needs 65536 clocks per tick. The bench sweeps prescale codes 0 to 6 with loads 1 to 3, and also runs codes 14 and 15 with a load of 1. For each run it checks that the request is still low one clock before L*D and high at L*D. The prescaler-restart rule is shown by reloading mid-period and checking that the next step comes a full period after the rewrite.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int EN_POS   = 7;
  localparam int MODE_LSB = 4;
  localparam int MODE_W   = 3;
  localparam int PSC_LSB  = 0;
  localparam int PSC_W    = 4;
  localparam int CTRL_W   = 8;
  localparam int WDT_MODE = 3;
  localparam int LOAD_OFS = 'h0;
  localparam int CTRL_OFS = 'h8;

  typedef struct packed {
    logic              en;
    logic [MODE_W-1:0] mode;
    logic [PSC_W-1:0]  psc;
  } ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PSC_W = 4,
  localparam int DIV_W = 2 ** PSC_W,
  localparam int EXP_W = PSC_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] code_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] mask;
  logic [EXP_W-1:0] exp_w;

  // code 0 -> divide by 1, otherwise 2^(code+1)
  assign exp_w = (code_i == '0) ? '0 : EXP_W'(code_i) + EXP_W'(1);

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(exp_w));
  end

  assign tick_o = run_i && ((phase_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (clr_i)  phase_q <= '0;
    else if (run_i)  phase_q <= phase_q + 1'b1;
  end

  a_r4_code0_every_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && code_i == '0) |-> tick_o);
  a_r5_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && code_i != '0) |=> !tick_o);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [DW-1:0]    rdata_o,
  output logic             load_we_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             ctrl_we_o,
  output ctrl_t            ctrl_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctrl_t ctrl_q;
  logic  sel_load, sel_ctrl;

  assign sel_load  = (addr_i == AW'(LOAD_OFS));
  assign sel_ctrl  = (addr_i == AW'(CTRL_OFS));
  assign load_we_o = we_i && sel_load;
  assign ctrl_we_o = we_i && sel_ctrl;

  // oversized loads clamp to the counter maximum
  assign load_val_o = (wdata_i > DW'(CNT_MAX)) ? CNT_MAX : wdata_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_o) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  assign ctrl_o = ctrl_q;

  always_comb begin
    rdata_o = '0;
    if (sel_load)      rdata_o[CNT_W-1:0]  = count_i;
    else if (sel_ctrl) rdata_o[CTRL_W-1:0] = ctrl_q;
  end

  a_r3_ctrl_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_o |=> $stable(ctrl_q));
  a_r1_ctrl_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_o |=> ctrl_q == $past(wdata_i[CTRL_W-1:0]));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             en_i,
  input  logic             wdt_mode_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic [CNT_W-1:0] count_o,
  output logic             req_o
);
  logic [CNT_W-1:0] count_q;
  logic             req_q;
  logic             last_step;

  assign run_o     = en_i && (count_q != '0) && !req_q;
  assign last_step = run_o && tick_i && (count_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                count_q <= '0;
    else if (load_we_i)         count_q <= load_val_i;
    else if (run_o && tick_i)   count_q <= count_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      req_q <= 1'b0;
    else if (last_step && wdt_mode_i) req_q <= 1'b1;
  end

  assign count_o = count_q;
  assign req_o   = req_q;

  a_r5_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && tick_i && !load_we_i) |=> count_q == $past(count_q) - 1'b1);
  a_r3_disabled_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_we_i) |=> $stable(count_q));
  a_r8_zero_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && !load_we_i) |=> count_q == '0);
  a_r7_req_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> req_q);
  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !load_we_i) |=> $stable(count_q));
  a_r9_other_mode_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_q && !wdt_mode_i) |=> !req_q);
  a_r6_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(count_q == CNT_W'(1) && en_i && tick_i));
endmodule

// File: rtl/prescaled_watchdog.sv
module prescaled_watchdog
  import wdt_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rst_req_o
);
  logic             load_we, ctrl_we, run, tick, req;
  logic [CNT_W-1:0] load_val, count;
  ctrl_t            ctrl;

  wdt_regs #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .count_i    (count),
    .rdata_o,
    .load_we_o  (load_we),
    .load_val_o (load_val),
    .ctrl_we_o  (ctrl_we),
    .ctrl_o     (ctrl)
  );

  wdt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i, .rst_ni,
    .run_i  (run),
    .clr_i  (load_we | ctrl_we),
    .code_i (ctrl.psc),
    .tick_o (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_we_i  (load_we),
    .load_val_i (load_val),
    .en_i       (ctrl.en),
    .wdt_mode_i (ctrl.mode == MODE_W'(WDT_MODE)),
    .tick_i     (tick),
    .run_o      (run),
    .count_o    (count),
    .req_o      (req)
  );

  assign rst_req_o = req;
endmodule

// File: tb/prescaled_watchdog_test.sv
module prescaled_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req;
  int          errors = 0;
  int          checks = 0;
  int          cycles = 0;

  prescaled_watchdog uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(req)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog timeout actual=%0d expected<=190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; we = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R6/R4: request low at L*D-1 clocks after the load edge, high at L*D
  task automatic expiry_run(input int code, input int load);
    int d;
    d = (code == 0) ? 1 : (1 << (code + 1));
    do_reset();
    wr(4'h8, 32'h80 | 32'h30 | code);
    wr(4'h0, load);
    step(load * d - 1);
    chk($sformatf("R4 R6 pre code=%0d L=%0d", code, load), {31'b0, req}, 32'd0);
    step(1);
    chk($sformatf("R4 R6 at code=%0d L=%0d", code, load), {31'b0, req}, 32'd1);
  endtask

  initial begin
    logic [31:0] v, c0;
    step(2);
    chk("R11 req in reset", {31'b0, req}, 32'd0);
    rst_n = 1'b1;
    step(1);
    rd(4'h0, v); chk("R11 count", v, 32'd0);
    rd(4'h8, v); chk("R11 ctrl", v, 32'd0);

    // R2 saturation, R1 readback and unmapped offsets
    wr(4'h0, 32'h0001_2345); rd(4'h0, v); chk("R2 clamp", v, 32'h0000_FFFF);
    wr(4'h0, 32'h0000_ABCD); rd(4'h0, v); chk("R2 passthrough", v, 32'h0000_ABCD);
    wr(4'h8, 32'h0000_0035); rd(4'h8, v); chk("R1 ctrl byte", v, 32'h35);
    wr(4'h8, 32'hFFFF_FF7F); rd(4'h8, v); chk("R1 ctrl upper zero", v, 32'h7F);
    rd(4'h4, v); chk("R1 offset 4", v, 32'd0);
    rd(4'hC, v); chk("R1 offset C", v, 32'd0);
    rd(4'h0, v); chk("R3 disabled count held", v, 32'h0000_ABCD);

    // R4/R6 sweep
    for (int code = 0; code <= 6; code++)
      for (int l = 1; l <= 3; l++) expiry_run(code, l);
    expiry_run(14, 1);
    expiry_run(15, 1);

    // R7: sticky request, counting frozen
    wr(4'h0, 32'd5);
    step(20);
    chk("R7 req sticky", {31'b0, req}, 32'd1);
    rd(4'h0, v); chk("R7 count frozen", v, 32'd5);
    do_reset();
    chk("R7 R11 req cleared by reset", {31'b0, req}, 32'd0);

    // R5: count readback at divisor 4 and prescaler restart on reload
    wr(4'h8, 32'hB1);
    wr(4'h0, 32'd10);
    rd(4'h0, v); chk("R5 k0", v, 32'd10);
    step(3); rd(4'h0, v); chk("R5 k3", v, 32'd10);
    step(1); rd(4'h0, v); chk("R5 k4", v, 32'd9);
    step(4); rd(4'h0, v); chk("R5 k8", v, 32'd8);
    step(2);                     // phase now 2 of 4
    wr(4'h0, 32'd10);
    step(3); rd(4'h0, v); chk("R5 reload phase k3", v, 32'd10);
    step(1); rd(4'h0, v); chk("R5 reload phase k4", v, 32'd9);

    // R3: clearing enable holds count
    do_reset();
    wr(4'h8, 32'hB0);
    wr(4'h0, 32'd20);
    step(4);
    wr(4'h8, 32'h30);
    rd(4'h0, c0); chk("R3 R5 count at disable", c0, 32'd14);
    step(10);
    rd(4'h0, v); chk("R3 held while disabled", v, c0);
    chk("R3 no req", {31'b0, req}, 32'd0);

    // R8: zero load parks
    do_reset();
    wr(4'h8, 32'hB0);
    wr(4'h0, 32'd0);
    step(50);
    rd(4'h0, v); chk("R8 count zero", v, 32'd0);
    chk("R8 no req", {31'b0, req}, 32'd0);

    // R9: other modes run down quietly
    do_reset();
    wr(4'h8, 32'h90);
    wr(4'h0, 32'd3);
    step(10);
    rd(4'h0, v); chk("R9 mode1 count", v, 32'd0);
    chk("R9 mode1 no req", {31'b0, req}, 32'd0);
    do_reset();
    wr(4'h8, 32'hF0);
    wr(4'h0, 32'd1);
    step(5);
    chk("R9 mode7 no req", {31'b0, req}, 32'd0);

    // R10: periodic service
    do_reset();
    wr(4'h8, 32'hB0);
    wr(4'h0, 32'd4);
    for (int i = 0; i < 20; i++) begin
      step(1);
      wr(4'h0, 32'd4);
    end
    chk("R10 serviced no req", {31'b0, req}, 32'd0);
    rd(4'h0, v); chk("R10 count nonzero", {31'b0, v != 0}, 32'd1);
    step(4);
    chk("R10 unserviced expires", {31'b0, req}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule